// File: doc/BRIEF.md
# ECC Engine Control and Status Front End

This block is the register front end of a page error-correction engine that has an encoder channel and a decoder channel. A simple request port carries register reads and writes. For each channel the block holds a run-enable register, a configuration word, an idle flag, an interrupt-enable register and a sticky interrupt-status bit that clears when read. The decoder side also keeps a done bitmask with one bit per sector and a packed register of per-sector error counts. One interrupt line combines the enabled status bits of both channels.

The channel datapaths are not part of this block. For each channel a small stepping stub stands in for the core. Once started, it spends a fixed number of cycles on each sector and pulses a done event with the sector index. The encoder performs one step. The decoder performs as many sectors as its configuration word asks for. Interrupt status can be raised on every finished step, or only when the last configured sector finishes (page granularity). Configuration words cannot be changed while their channel is busy.

Top module: `ecc_csr_front`

## Requirements
- R1: After reset both run outputs and the interrupt are 0. Both idle registers (encoder 0x00C, decoder 0x10C) read 1 in bit 0. Both status registers (encoder 0x024, decoder 0x124) read 0. Both configuration registers (encoder 0x004, decoder 0x104) read 0.
- R2: Writing bit 0 = 1 to an enable register (encoder 0x000, decoder 0x100) sets the channel's run output and starts it, and its idle bit reads 0 while it is busy. Writing 0 stops the channel at once, so that run is 0 and idle reads 1.
- R3: A configuration register reads back the written word ANDed with the implemented fields. Those fields are the strength index [4:0], mode [5], message bits [30:16], and for the decoder only sector-count-minus-one [9:8], correction enable [13:12] and empty-page detect [31]. The encoder mask is 0x7FFF003F and the decoder mask is 0xFFFF333F. For the decoder, the message field is expected to hold data bytes times 8 plus strength times 14.
- R4: A write to a configuration register is ignored while that channel is busy.
- R5: A started decoder processes (field [9:8] + 1) sectors in order, each taking STEP_CYC cycles. Bit s of the done register (0x128) is set when sector s finishes. The whole register clears when a run starts.
- R6: Interrupt-enable bit 1 (encoder 0x020, decoder 0x120) selects the granularity. When it is 0, the status bit sets on every finished step. When it is 1, the status bit sets only when the last configured sector finishes.
- R7: A read of a status register returns its bit 0 and then clears it, so a second read returns 0. If a status set and a read arrive in the same cycle, the set wins.
- R8: irq is 1 exactly when some channel has its status bit set and interrupt-enable bit 0 set. A status bit still sets while its interrupt is disabled.
- R9: Lane s of the error register (0x130, bits [8s+7:8s]) is set to (5*s + strength index) mod 32 when sector s finishes. Lanes clear when a run starts.
- R10: A started encoder performs a single step of STEP_CYC cycles, then reads idle and sets its status bit. Its run output stays 1 until 0 is written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Register access this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte offset of the register |
| req_wdata | input | 32 | Write data |
| rd_data | output | 32 | Read data, valid in the same cycle as the read request |
| irq | output | 1 | Combined interrupt |
| enc_run | output | 1 | Encoder enable line to the core |
| dec_run | output | 1 | Decoder enable line to the core |

## Verification
The decoder is swept over every sector count, three strength indices and both interrupt granularities. During each run the status register is read every cycle. Counting the reads that return 1 separates per-step from page granularity, and it also shows whether read-clear works: a status bit that never cleared would be counted far too often. After each run the done mask and the error lanes are compared with values computed from the sector count and the index, which exposes wrong sector ordering or wrong lane positions. Separate directed runs cover a stop in mid-run, configuration writes while busy, interrupt gating with each enable setting, and single-step encoder runs.

// File: rtl/ecc_csr_pkg.sv
package ecc_csr_pkg;
  // register offsets (channel decode depends on these)
  localparam int A_ENC_EN   = 'h000;
  localparam int A_ENC_CFG  = 'h004;
  localparam int A_ENC_IDLE = 'h00C;
  localparam int A_ENC_IE   = 'h020;
  localparam int A_ENC_STA  = 'h024;
  localparam int A_DEC_EN   = 'h100;
  localparam int A_DEC_CFG  = 'h104;
  localparam int A_DEC_IDLE = 'h10C;
  localparam int A_DEC_IE   = 'h120;
  localparam int A_DEC_STA  = 'h124;
  localparam int A_DEC_DONE = 'h128;
  localparam int A_DEC_ERR  = 'h130;

  // configuration word fields
  localparam int IDX_W     = 5;
  localparam int NSEC_LSB  = 8;
  localparam logic [31:0] ENC_CFG_MASK  = 32'h7FFF_003F;
  localparam logic [31:0] DEC_BASE_MASK = 32'hFFFF_303F;

  // error count reported by the stepping stub for one sector
  function automatic logic [7:0] stub_err(input int unsigned sec,
                                          input int unsigned idx,
                                          input int unsigned mask);
    return 8'((sec * 5 + idx) & mask);
  endfunction
endpackage

// File: rtl/ecc_step_stub.sv
module ecc_step_stub #(
  parameter int STEP_CYC = 6,
  parameter int SEC_W    = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             stop,
  input  logic [SEC_W-1:0] last_sec,
  output logic             busy,
  output logic             done_evt,
  output logic [SEC_W-1:0] evt_sec
);
  localparam int CNT_W = (STEP_CYC > 2) ? $clog2(STEP_CYC) : 1;
  localparam logic [CNT_W-1:0] CNT_END = CNT_W'(STEP_CYC - 1);

  logic [CNT_W-1:0] cnt_q;
  logic [SEC_W-1:0] sec_q;

  assign done_evt = busy && (cnt_q == CNT_END) && !stop;
  assign evt_sec  = sec_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      cnt_q <= '0;
      sec_q <= '0;
    end else if (stop) begin
      busy <= 1'b0;
    end else if (start && !busy) begin
      busy  <= 1'b1;
      cnt_q <= '0;
      sec_q <= '0;
    end else if (busy) begin
      if (cnt_q == CNT_END) begin
        cnt_q <= '0;
        if (sec_q == last_sec) busy <= 1'b0;
        else                   sec_q <= sec_q + 1'b1;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/ecc_irq_stat.sv
module ecc_irq_stat (
  input  logic clk,
  input  logic rst_n,
  input  logic evt,
  input  logic evt_last,
  input  logic page_mode,
  input  logic rd_clr,
  output logic sta
);
  logic set_now;
  assign set_now = evt && (!page_mode || evt_last);

  always_ff @(posedge clk) begin
    if (!rst_n)       sta <= 1'b0;
    else if (set_now) sta <= 1'b1;
    else if (rd_clr)  sta <= 1'b0;
  end
endmodule

// File: rtl/ecc_csr_front.sv
module ecc_csr_front
  import ecc_csr_pkg::*;
#(
  parameter int ADDR_W   = 12,
  parameter int NSECT    = 4,
  parameter int STEP_CYC = 6,
  parameter int ERR_W    = 5,
  parameter int LANE_W   = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [31:0]       req_wdata,
  output logic [31:0]       rd_data,
  output logic              irq,
  output logic              enc_run,
  output logic              dec_run
);
  localparam int SEC_W = (NSECT > 2) ? $clog2(NSECT) : 1;
  localparam int ERRWORD_W = NSECT * LANE_W;
  localparam int unsigned ERR_MASK = (1 << ERR_W) - 1;
  localparam logic [31:0] DEC_CFG_MASK =
    DEC_BASE_MASK | (32'((1 << SEC_W) - 1) << NSEC_LSB);

  // access decode
  logic wr, rd;
  assign wr = req_valid && req_write;
  assign rd = req_valid && !req_write;

  function automatic logic hit(input logic [ADDR_W-1:0] a, input int off);
    return a == ADDR_W'(off);
  endfunction

  // named internal events
  logic              enc_busy, dec_busy;
  logic              enc_start, dec_start, enc_stop, dec_stop;
  logic              enc_done_evt, dec_done_evt;
  logic [SEC_W-1:0]  enc_evt_sec, dec_evt_sec, dec_last;
  logic              enc_evt_last, dec_evt_last;
  logic              enc_cfg_wr, dec_cfg_wr;
  logic              enc_sta_rd, dec_sta_rd;
  logic              enc_sta, dec_sta;
  logic [31:0]       enc_cfg_q, dec_cfg_q;
  logic [1:0]        enc_ie_q, dec_ie_q;
  logic [NSECT-1:0]  dec_done_q;
  logic [ERRWORD_W-1:0] err_word;

  assign enc_start  = wr && hit(req_addr, A_ENC_EN) && req_wdata[0];
  assign enc_stop   = wr && hit(req_addr, A_ENC_EN) && !req_wdata[0];
  assign dec_start  = wr && hit(req_addr, A_DEC_EN) && req_wdata[0] && !dec_busy;
  assign dec_stop   = wr && hit(req_addr, A_DEC_EN) && !req_wdata[0];
  assign enc_cfg_wr = wr && hit(req_addr, A_ENC_CFG) && !enc_busy;
  assign dec_cfg_wr = wr && hit(req_addr, A_DEC_CFG) && !dec_busy;
  assign enc_sta_rd = rd && hit(req_addr, A_ENC_STA);
  assign dec_sta_rd = rd && hit(req_addr, A_DEC_STA);
  assign dec_last   = dec_cfg_q[NSEC_LSB +: SEC_W];

  // control registers
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      enc_run   <= 1'b0;
      dec_run   <= 1'b0;
      enc_cfg_q <= '0;
      dec_cfg_q <= '0;
      enc_ie_q  <= '0;
      dec_ie_q  <= '0;
    end else begin
      if (wr && hit(req_addr, A_ENC_EN)) enc_run <= req_wdata[0];
      if (wr && hit(req_addr, A_DEC_EN)) dec_run <= req_wdata[0];
      if (enc_cfg_wr) enc_cfg_q <= req_wdata & ENC_CFG_MASK;
      if (dec_cfg_wr) dec_cfg_q <= req_wdata & DEC_CFG_MASK;
      if (wr && hit(req_addr, A_ENC_IE)) enc_ie_q <= req_wdata[1:0];
      if (wr && hit(req_addr, A_DEC_IE)) dec_ie_q <= req_wdata[1:0];
    end
  end

  // core stand-ins
  ecc_step_stub #(.STEP_CYC(STEP_CYC), .SEC_W(SEC_W)) u_enc_core (
    .clk(clk), .rst_n(rst_n), .start(enc_start), .stop(enc_stop),
    .last_sec('0), .busy(enc_busy), .done_evt(enc_done_evt),
    .evt_sec(enc_evt_sec));

  ecc_step_stub #(.STEP_CYC(STEP_CYC), .SEC_W(SEC_W)) u_dec_core (
    .clk(clk), .rst_n(rst_n), .start(dec_start), .stop(dec_stop),
    .last_sec(dec_last), .busy(dec_busy), .done_evt(dec_done_evt),
    .evt_sec(dec_evt_sec));

  assign enc_evt_last = enc_done_evt && (enc_evt_sec == '0);
  assign dec_evt_last = dec_done_evt && (dec_evt_sec == dec_last);

  // interrupt status
  ecc_irq_stat u_enc_sta (
    .clk(clk), .rst_n(rst_n), .evt(enc_done_evt), .evt_last(enc_evt_last),
    .page_mode(enc_ie_q[1]), .rd_clr(enc_sta_rd), .sta(enc_sta));

  ecc_irq_stat u_dec_sta (
    .clk(clk), .rst_n(rst_n), .evt(dec_done_evt), .evt_last(dec_evt_last),
    .page_mode(dec_ie_q[1]), .rd_clr(dec_sta_rd), .sta(dec_sta));

  assign irq = (enc_sta && enc_ie_q[0]) || (dec_sta && dec_ie_q[0]);

  // per-sector done bits and error lanes
  for (genvar s = 0; s < NSECT; s++) begin : g_sect
    logic [LANE_W-1:0] lane_q;
    always_ff @(posedge clk) begin
      if (!rst_n || dec_start) begin
        dec_done_q[s] <= 1'b0;
        lane_q        <= '0;
      end else if (dec_done_evt && (dec_evt_sec == SEC_W'(s))) begin
        dec_done_q[s] <= 1'b1;
        lane_q <= LANE_W'(stub_err(s, int'(dec_cfg_q[IDX_W-1:0]), ERR_MASK));
      end
    end
    assign err_word[s*LANE_W +: LANE_W] = lane_q;
  end

  // read mux
  always_comb begin
    rd_data = '0;
    if (rd) begin
      if      (hit(req_addr, A_ENC_EN))   rd_data[0]   = enc_run;
      else if (hit(req_addr, A_ENC_CFG))  rd_data      = enc_cfg_q;
      else if (hit(req_addr, A_ENC_IDLE)) rd_data[0]   = !enc_busy;
      else if (hit(req_addr, A_ENC_IE))   rd_data[1:0] = enc_ie_q;
      else if (hit(req_addr, A_ENC_STA))  rd_data[0]   = enc_sta;
      else if (hit(req_addr, A_DEC_EN))   rd_data[0]   = dec_run;
      else if (hit(req_addr, A_DEC_CFG))  rd_data      = dec_cfg_q;
      else if (hit(req_addr, A_DEC_IDLE)) rd_data[0]   = !dec_busy;
      else if (hit(req_addr, A_DEC_IE))   rd_data[1:0] = dec_ie_q;
      else if (hit(req_addr, A_DEC_STA))  rd_data[0]   = dec_sta;
      else if (hit(req_addr, A_DEC_DONE)) rd_data      = 32'(dec_done_q);
      else if (hit(req_addr, A_DEC_ERR))  rd_data      = 32'(err_word);
    end
  end
endmodule

// File: rtl/ecc_csr_chk.sv
module ecc_csr_chk #(
  parameter int NSECT = 4,
  parameter int SEC_W = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             irq,
  input logic             dec_run,
  input logic             dec_busy,
  input logic             dec_start,
  input logic             dec_done_evt,
  input logic             dec_evt_last,
  input logic             dec_sta,
  input logic             dec_sta_rd,
  input logic [31:0]      dec_cfg_q,
  input logic [NSECT-1:0] dec_done_q,
  input logic [1:0]       enc_ie_q,
  input logic [1:0]       dec_ie_q
);
  // R7
  sta_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_sta_rd && !dec_done_evt) |=> !dec_sta);

  // R4
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dec_busy |=> $stable(dec_cfg_q));

  // R5
  mask_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dec_start |=> (dec_done_q == '0));

  // R6
  page_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_ie_q[1] && dec_done_evt && !dec_evt_last && !dec_sta_rd) |=> $stable(dec_sta));

  // R8
  irq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!enc_ie_q[0] && !dec_ie_q[0]) |-> !irq);

  // R2
  busy_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dec_busy |-> dec_run);
endmodule

bind ecc_csr_front ecc_csr_chk #(.NSECT(NSECT), .SEC_W(SEC_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .irq(irq), .dec_run(dec_run),
  .dec_busy(dec_busy), .dec_start(dec_start), .dec_done_evt(dec_done_evt),
  .dec_evt_last(dec_evt_last), .dec_sta(dec_sta), .dec_sta_rd(dec_sta_rd),
  .dec_cfg_q(dec_cfg_q), .dec_done_q(dec_done_q), .enc_ie_q(enc_ie_q),
  .dec_ie_q(dec_ie_q));

// File: tb/test_ecc_csr_front.sv
module test_ecc_csr_front;
  localparam int STEP = 6;
  localparam int NS   = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [11:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic [31:0] rd_data;
  logic        irq, enc_run, dec_run;

  int n_vec = 0, n_bad = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  ecc_csr_front #(.NSECT(NS), .STEP_CYC(STEP)) i_ecc_csr_front (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .rd_data(rd_data),
    .irq(irq), .enc_run(enc_run), .dec_run(dec_run));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
    @(posedge clk); #1;
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = a;
    #1 d = rd_data;
    @(posedge clk); #1;
    req_valid = 1'b0;
  endtask

  task automatic rchk(input string req, input logic [11:0] a, input logic [31:0] exp);
    logic [31:0] d;
    rd(a, d);
    chk(req, d, exp);
  endtask

  task automatic pins(input string req, input logic act, input logic exp);
    @(negedge clk); #1;
    chk(req, 32'(act), 32'(exp));
  endtask

  function automatic int dec_bits(input int bytes, input int strength);
    return bytes * 8 + strength * 14;
  endfunction

  initial begin
    #(200000 * 4);
    if (!finished) begin
      n_vec++; n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1 reset state
    pins("R1 enc_run", enc_run, 1'b0);
    pins("R1 dec_run", dec_run, 1'b0);
    pins("R1 irq", irq, 1'b0);
    rchk("R1 enc idle", 12'h00C, 32'h1);
    rchk("R1 dec idle", 12'h10C, 32'h1);
    rchk("R1 enc sta", 12'h024, 32'h0);
    rchk("R1 dec sta", 12'h124, 32'h0);
    rchk("R1 enc cfg", 12'h004, 32'h0);
    rchk("R1 dec cfg", 12'h104, 32'h0);

    // R3 configuration readback masks
    begin
      logic [31:0] pats [3];
      pats[0] = 32'hFFFF_FFFF;
      pats[1] = 32'hA5A5_A5A5;
      pats[2] = (32'(dec_bits(512, 24)) << 16) | 32'h8000_3123;
      foreach (pats[i]) begin
        wr(12'h004, pats[i]);
        rchk("R3 enc cfg", 12'h004, pats[i] & 32'h7FFF_003F);
        wr(12'h104, pats[i]);
        rchk("R3 dec cfg", 12'h104, pats[i] & 32'hFFFF_333F);
      end
    end

    // R5 R6 R7 R9 sweep over sector counts, indices, granularity
    for (int pm = 0; pm < 2; pm++) begin
      for (int ns = 0; ns < NS; ns++) begin
        for (int k = 0; k < 3; k++) begin
          int idx, ones, nloops;
          logic [31:0] cfgw, exp_mask, exp_err;
          idx = (k == 0) ? 0 : (k == 1) ? 7 : 19;
          cfgw = (32'(dec_bits(1024, idx * 2 + 4)) << 16) | 32'h8000_3020 |
                 (32'(ns) << 8) | 32'(idx);
          wr(12'h104, cfgw);
          wr(12'h120, 32'(pm * 2 + 1));
          wr(12'h100, 32'h1);
          ones = 0;
          nloops = (ns + 1) * STEP + 6;
          for (int t = 0; t < nloops; t++) begin
            rd(12'h124, d);
            if (d[0]) ones++;
          end
          chk(pm ? "R6 page-mode status count" : "R6 R7 per-step status count",
              32'(ones), pm ? 32'd1 : 32'(ns + 1));
          exp_mask = 32'((1 << (ns + 1)) - 1);
          rchk("R5 done mask", 12'h128, exp_mask);
          exp_err = '0;
          for (int s = 0; s <= ns; s++)
            exp_err = exp_err | (32'((5 * s + idx) % 32) << (8 * s));
          rchk("R9 error lanes", 12'h130, exp_err);
          rchk("R2 idle after run", 12'h10C, 32'h1);
          pins("R8 irq low after clear", irq, 1'b0);
        end
      end
    end

    // R8 R7 interrupt gating and read-clear with nsect = 1
    wr(12'h104, 32'h0000_0005);
    wr(12'h120, 32'h1);
    wr(12'h100, 32'h1);
    repeat (STEP + 3) @(posedge clk);
    pins("R8 irq set", irq, 1'b1);
    rchk("R7 first read", 12'h124, 32'h1);
    pins("R8 irq cleared by read", irq, 1'b0);
    rchk("R7 second read", 12'h124, 32'h0);
    wr(12'h120, 32'h0);
    wr(12'h100, 32'h1);
    repeat (STEP + 3) @(posedge clk);
    pins("R8 irq masked", irq, 1'b0);
    rchk("R8 status sets while masked", 12'h124, 32'h1);

    // R2 stop mid-run, R5 mask cleared by start
    wr(12'h104, 32'h0000_0300);
    wr(12'h100, 32'h1);
    rchk("R2 dec busy idle=0", 12'h10C, 32'h0);
    pins("R2 dec_run high", dec_run, 1'b1);
    wr(12'h100, 32'h0);
    rchk("R2 dec idle after stop", 12'h10C, 32'h1);
    pins("R2 dec_run low", dec_run, 1'b0);
    rchk("R5 mask cleared at start", 12'h128, 32'h0);

    // R4 config write ignored while busy
    wr(12'h100, 32'h1);
    wr(12'h104, 32'h0000_0011);
    rchk("R4 cfg held while busy", 12'h104, 32'h0000_0300);
    repeat (4 * STEP + 4) @(posedge clk);
    wr(12'h104, 32'h0000_0011);
    rchk("R4 cfg accepted when idle", 12'h104, 32'h0000_0011);

    // R10 encoder single step
    wr(12'h020, 32'h1);
    wr(12'h000, 32'h1);
    rchk("R10 enc busy", 12'h00C, 32'h0);
    pins("R2 enc_run high", enc_run, 1'b1);
    repeat (STEP + 2) @(posedge clk);
    rchk("R10 enc idle after one step", 12'h00C, 32'h1);
    pins("R10 enc irq", irq, 1'b1);
    pins("R10 enc_run stays", enc_run, 1'b1);
    rchk("R10 enc status", 12'h024, 32'h1);
    rchk("R7 enc status cleared", 12'h024, 32'h0);
    wr(12'h000, 32'h0);
    pins("R2 enc_run low", enc_run, 1'b0);

    finished = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule